// File: doc/BRIEF.md
# Integrating Converter Run-Down Slope Controller

This block runs the run-down phase of a multi-slope integrating analog-to-digital converter. A host command starts run-down and supplies the slope-control code to drive. From the next cycle that code is applied to the integrator. The block watches the integrator's zero comparator through a synchroniser. It removes the slope in hardware on the first synchronised sample that differs from the comparator level captured at the start command. No software sits in that decision path, so the overshoot past zero stays short.

The crossing is latched. Comparator chatter around zero after shut-off cannot bring the slope back, and only a new start command re-arms the block. While the slope is on, the block measures its duration. A raw timing clock is re-registered into the system clock domain. Each detected edge of that clock advances an interval counter made of a narrow prescaler stage and a wider upper stage. If the counter saturates before any crossing, the slope is forced off and an overflow flag is raised. One cycle after the slope goes off, a done pulse tells the host that the count is final. The count then stays unchanged until the next accepted start.

Top module: `rundown_ctrl`

## Requirements
- R1: While synchronous reset `rst` is high, and on the first cycle after it, `slope_en` is zero, and `busy`, `done`, `overflow` and `count` are all zero.
- R2: A `start` sampled high while `busy` is low makes `slope_en` equal to the `init_slope` sampled on that edge, and `busy` goes high, both from the next cycle. The same edge clears `count` and `overflow`.
- R3: `cmp_in` passes through a two-stage synchroniser. If `cmp_in` changes just before clock edge e while run-down is active, `slope_en` is still driven after edges e and e+1 and reads zero after edge e+2.
- R4: Once the slope has been removed, further comparator transitions in either direction leave `slope_en` at zero until the next accepted start.
- R5: `count` is the number of rising edges of `tick_in` that appear at the output of its two-flop re-register while run-down is active. The low 4 bits act as a prescaler whose carry advances the upper bits. `count` is held unchanged from slope-off until the next accepted start.
- R6: `done` is a single-cycle pulse in the cycle after `slope_en` goes to zero. In that cycle `busy` is already low.
- R7: If `count` is all ones while run-down is active and no crossing is seen on that edge, the slope is forced off on that edge and `overflow` is set. `count` never wraps. A crossing on the same edge takes priority and leaves `overflow` clear.
- R8: A `start` that arrives while `busy` is high has no effect on `slope_en`, `count` or the ongoing run.
- R9: Asserting `rst` during an active run-down returns the block to idle, with all slopes disabled and `count` zero, on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Run-down start command |
| init_slope | input | SLOPE_W (3) | Slope-control code applied during run-down |
| cmp_in | input | 1 | Asynchronous integrator zero comparator |
| tick_in | input | 1 | Raw timing clock, re-registered inside |
| slope_en | output | SLOPE_W (3) | Slope-control code to the integrator, zero when off |
| busy | output | 1 | Run-down in progress |
| done | output | 1 | One-cycle pulse after slope-off |
| overflow | output | 1 | Interval counter saturated before a crossing |
| count | output | CNT_W (20) | Measured slope-on interval |

## Verification
Directed runs check the exact three-edge latency from a comparator change to slope-off. They also place exactly twenty timing edges inside one run, which is enough to carry out of the prescaler into the upper stage. Another directed run holds the comparator still until the counter saturates, which separates the forced shut-off path from the crossing path. Further runs send a second start mid-run and a reset mid-run.

Randomised runs vary the slope codes, the comparator level at start, the run length and the timing-clock toggling. They also add a glitch that returns the comparator to its old level one or two cycles after a crossing. These runs are compared cycle by cycle against a reference model in the bench. A missing latch, a wrong synchroniser depth or a miscounted edge shows up there as a mismatch on a named output.

// File: rtl/rd_pkg.sv
package rd_pkg;
   typedef enum logic [1:0] {
      RD_IDLE = 2'd0,
      RD_RUN  = 2'd1,
      RD_FIN  = 2'd2
   } rd_state_e;
endpackage

// File: rtl/rd_sync.sv
// Multi-stage level synchroniser for the asynchronous comparator input.
module rd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rd_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rd_tick_retime.sv
// Re-registers the raw timing clock and turns its edges into one-cycle strobes.
module rd_tick_retime #(
   parameter bit BOTH_EDGES = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic tick_raw,
   output logic strobe
);
   logic t_q, t_qq;

   always_ff @(posedge clk) begin
      if (rst) begin
         t_q  <= 1'b0;
         t_qq <= 1'b0;
      end else begin
         t_q  <= tick_raw;
         t_qq <= t_q;
      end
   end

   if (BOTH_EDGES) begin : g_both
      assign strobe = t_q ^ t_qq;
   end else begin : g_rise
      assign strobe = t_q & ~t_qq;
   end

   // R5: a strobe never lasts two cycles in rising-edge mode
   if (!BOTH_EDGES) begin : g_chk
      a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
         strobe |=> !strobe);
   end
endmodule

// File: rtl/rd_interval_count.sv
// Saturating interval counter: a prescaler stage feeding an upper stage.
module rd_interval_count #(
   parameter int CNT_W = 20,
   parameter int PRE_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             en,
   output logic [CNT_W-1:0] value,
   output logic             full
);
   localparam int HI_W = CNT_W - PRE_W;

   if (PRE_W < 1 || HI_W < 1) begin : g_bad_split
      $error("rd_interval_count: need 1 <= PRE_W < CNT_W");
   end

   logic [PRE_W-1:0] pre_q;
   logic [HI_W-1:0]  hi_q;
   logic             step;
   logic             carry;

   assign full  = (&pre_q) & (&hi_q);
   assign step  = en & ~full;
   assign carry = step & (&pre_q);

   always_ff @(posedge clk) begin
      if (rst || clr)  pre_q <= '0;
      else if (step)   pre_q <= pre_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst || clr)  hi_q <= '0;
      else if (carry)  hi_q <= hi_q + 1'b1;
   end

   assign value = {hi_q, pre_q};

   // R7: once saturated the counter stays saturated until cleared
   a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
      (full && !clr) |=> full);
   // R5: without enable or clear the value does not move
   a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      (!en && !clr) |=> $stable(value));
endmodule

// File: rtl/rundown_ctrl.sv
module rundown_ctrl #(
   parameter int SLOPE_W         = 3,
   parameter int CNT_W           = 20,
   parameter int PRE_W           = 4,
   parameter int SYNC_STAGES     = 2,
   parameter bit TICK_BOTH_EDGES = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic [SLOPE_W-1:0] init_slope,
   input  logic               cmp_in,
   input  logic               tick_in,
   output logic [SLOPE_W-1:0] slope_en,
   output logic               busy,
   output logic               done,
   output logic               overflow,
   output logic [CNT_W-1:0]   count
);
   import rd_pkg::*;

   if (SLOPE_W < 1) begin : g_bad_slope
      $error("rundown_ctrl: SLOPE_W must be positive");
   end

   rd_state_e          state_q;
   logic [SLOPE_W-1:0] slope_q;
   logic               ref_q;
   logic               done_q;
   logic               ovf_q;
   logic               cmp_s;
   logic               strobe;
   logic               cnt_full;
   logic               accept;
   logic               crossed;

   rd_sync #(.STAGES(SYNC_STAGES)) u_cmp_sync (
      .clk (clk),
      .rst (rst),
      .d   (cmp_in),
      .q   (cmp_s)
   );

   rd_tick_retime #(.BOTH_EDGES(TICK_BOTH_EDGES)) u_tick (
      .clk      (clk),
      .rst      (rst),
      .tick_raw (tick_in),
      .strobe   (strobe)
   );

   assign accept  = (state_q == RD_IDLE) & start;
   assign crossed = (state_q == RD_RUN) & (cmp_s != ref_q);

   rd_interval_count #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr   (accept),
      .en    ((state_q == RD_RUN) & strobe),
      .value (count),
      .full  (cnt_full)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= RD_IDLE;
         slope_q <= '0;
         ref_q   <= 1'b0;
         done_q  <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            RD_IDLE: begin
               if (start) begin
                  slope_q <= init_slope;
                  ref_q   <= cmp_s;
                  ovf_q   <= 1'b0;
                  state_q <= RD_RUN;
               end
            end
            RD_RUN: begin
               if (crossed) begin
                  slope_q <= '0;
                  state_q <= RD_FIN;
               end else if (cnt_full) begin
                  slope_q <= '0;
                  ovf_q   <= 1'b1;
                  state_q <= RD_FIN;
               end
            end
            RD_FIN: begin
               done_q  <= 1'b1;
               state_q <= RD_IDLE;
            end
            default: state_q <= RD_IDLE;
         endcase
      end
   end

   assign slope_en = slope_q;
   assign busy     = (state_q != RD_IDLE);
   assign done     = done_q;
   assign overflow = ovf_q;

   // R4: an off slope stays off unless a start is accepted
   a_r4_latched_off: assert property (@(posedge clk) disable iff (rst)
      (slope_en == '0 && !(start && !busy)) |=> (slope_en == '0));
   // R6: done lasts one cycle and comes with the slope off and the block idle
   a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
      done |-> (slope_en == '0 && !busy));
   // R7: overflow implies the slope is off
   a_r7_ovf_off: assert property (@(posedge clk) disable iff (rst)
      overflow |-> (slope_en == '0));
   // R5: count frozen while idle with no start
   a_r5_count_held: assert property (@(posedge clk) disable iff (rst)
      (!busy && !start) |=> $stable(count));
   // R8: a start while busy does not reload the slope code
   a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
      (busy && start && slope_en != '0) |=> (slope_en == '0 || $stable(slope_en)));
endmodule

// File: tb/rundown_ctrl_tb.sv
module rundown_ctrl_tb;
   localparam int SW = 3;
   localparam int CW = 10;
   localparam logic [CW-1:0] CMAX = '1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic [SW-1:0] init_slope = '0;
   logic          cmp_in = 1'b0;
   logic          tick_in = 1'b0;
   logic [SW-1:0] slope_en;
   logic          busy, done, overflow;
   logic [CW-1:0] count;

   int checks = 0;
   int errors = 0;
   int tick_mode = 0;   // 0 directed, 1 toggle each cycle, 2 random toggles
   int cyc = 0;

   always #2 clk = ~clk;

   rundown_ctrl #(.SLOPE_W(SW), .CNT_W(CW), .PRE_W(4)) u_dut (
      .clk(clk), .rst(rst), .start(start), .init_slope(init_slope),
      .cmp_in(cmp_in), .tick_in(tick_in), .slope_en(slope_en),
      .busy(busy), .done(done), .overflow(overflow), .count(count));

   // ---------------- reference model built from the requirements ----------
   logic          m_s1 = 0, m_s2 = 0, m_t1 = 0, m_t2 = 0, m_ref = 0;
   logic          m_done = 0, m_ovf = 0;
   logic [SW-1:0] m_slope = '0;
   logic [CW-1:0] m_cnt = '0;
   int            m_st = 0;   // 0 idle, 1 run, 2 finishing

   function automatic logic [CW-1:0] next_count(logic [CW-1:0] c, logic edge_seen, int st);
      if (st == 1 && edge_seen && c != CMAX) return c + 1'b1;
      return c;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_s1 <= 0; m_s2 <= 0; m_t1 <= 0; m_t2 <= 0; m_ref <= 0;
         m_done <= 0; m_ovf <= 0; m_slope <= '0; m_cnt <= '0; m_st <= 0;
      end else begin
         m_s1 <= cmp_in; m_s2 <= m_s1;
         m_t1 <= tick_in; m_t2 <= m_t1;
         m_done <= 0;
         m_cnt <= next_count(m_cnt, m_t1 & ~m_t2, m_st);
         if (m_st == 0) begin
            if (start) begin
               m_slope <= init_slope; m_ref <= m_s2; m_ovf <= 0;
               m_cnt <= '0; m_st <= 1;
            end
         end else if (m_st == 1) begin
            if (m_s2 != m_ref) begin
               m_slope <= '0; m_st <= 2;
            end else if (m_cnt == CMAX) begin
               m_slope <= '0; m_ovf <= 1; m_st <= 2;
            end
         end else begin
            m_done <= 1; m_st <= 0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      cyc++;
      if (!rst) begin
         chk(slope_en == m_slope, "R3", "slope_en vs model", slope_en, m_slope);
         chk(count == m_cnt, "R5", "count vs model", count, m_cnt);
         chk(done == m_done, "R6", "done vs model", done, m_done);
         chk(overflow == m_ovf, "R7", "overflow vs model", overflow, m_ovf);
         chk(busy == (m_st != 0), "R8", "busy vs model", busy, m_st != 0);
      end
      if (tick_mode == 1) tick_in <= ~tick_in;
      else if (tick_mode == 2 && ($urandom % 3 == 0)) tick_in <= ~tick_in;
   end

   // watchdog
   always @(negedge clk) begin
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start(input logic [SW-1:0] code);
      start <= 1'b1; init_slope <= code;
      @(negedge clk);
      start <= 1'b0;
   endtask

   task automatic wait_idle(input int limit);
      for (int i = 0; i < limit && busy; i++) @(negedge clk);
      wait_n(2);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      wait_n(3);
      // R1: reset state
      chk(slope_en == '0 && !busy && !done && !overflow && count == '0,
          "R1", "outputs under reset", {slope_en, busy, done, overflow}, 0);
      rst <= 1'b0;
      @(negedge clk);
      chk(slope_en == '0 && count == '0 && !busy, "R1", "after reset release",
          {slope_en, busy}, 0);

      // R2 / R3 / R6 / R4: exact latency and latch
      cmp_in <= 1'b0; tick_in <= 1'b0; wait_n(4);
      do_start(3'b101);
      chk(slope_en == 3'b101, "R2", "slope code applied", slope_en, 5);
      chk(busy == 1'b1, "R2", "busy after start", busy, 1);
      wait_n(5);
      cmp_in <= 1'b1;
      @(negedge clk);
      chk(slope_en == 3'b101, "R3", "still on after 1 edge", slope_en, 5);
      @(negedge clk);
      chk(slope_en == 3'b101, "R3", "still on after 2 edges", slope_en, 5);
      @(negedge clk);
      chk(slope_en == '0, "R3", "off after 3 edges", slope_en, 0);
      cmp_in <= 1'b0;   // noise straight back
      @(negedge clk);
      chk(done == 1'b1 && !busy, "R6", "done pulse", done, 1);
      @(negedge clk);
      chk(done == 1'b0, "R6", "done single cycle", done, 0);
      for (int i = 0; i < 6; i++) begin
         cmp_in <= ~cmp_in;
         @(negedge clk);
         chk(slope_en == '0, "R4", "slope stays off on comparator noise", slope_en, 0);
      end
      cmp_in <= 1'b0; wait_n(4);

      // R5: twenty edges, carry out of the prescaler, then hold
      do_start(3'b010);
      for (int i = 0; i < 20; i++) begin
         tick_in <= 1'b1; @(negedge clk);
         tick_in <= 1'b0; @(negedge clk);
      end
      wait_n(4);
      cmp_in <= 1'b1;
      wait_n(6);
      chk(count == CW'(20), "R5", "twenty timing edges counted", count, 20);
      tick_mode = 1; wait_n(20); tick_mode = 0; tick_in <= 1'b0;
      chk(count == CW'(20), "R5", "count held after slope-off", count, 20);

      // R8: start while busy ignored
      wait_n(4);
      do_start(3'b011);
      wait_n(5);
      begin
         logic [CW-1:0] c_before;
         c_before = count;
         do_start(3'b110);
         wait_n(2);
         chk(slope_en == 3'b011, "R8", "slope code kept on second start", slope_en, 3);
         chk(busy && count >= c_before, "R8", "run not restarted", count, c_before);
      end
      cmp_in <= 1'b0;
      wait_idle(100);

      // R7: saturation forces slope off
      tick_mode = 1;
      do_start(3'b111);
      wait_idle(6000);
      tick_mode = 0; tick_in <= 1'b0;
      chk(overflow == 1'b1, "R7", "overflow flag", overflow, 1);
      chk(count == CMAX, "R7", "count saturated, no wrap", count, CMAX);
      chk(slope_en == '0, "R7", "slope forced off", slope_en, 0);

      // R9: reset mid-run
      wait_n(3);
      do_start(3'b001);
      wait_n(5);
      rst <= 1'b1; @(negedge clk); rst <= 1'b0;
      @(negedge clk);
      chk(slope_en == '0 && !busy && count == '0, "R9", "reset during run",
          {slope_en, busy}, 0);
      chk(overflow == 1'b0, "R9", "overflow cleared by reset", overflow, 0);

      // randomised runs against the model
      tick_mode = 2;
      for (int it = 0; it < 250; it++) begin
         wait_n(3 + ($urandom % 3));
         do_start(SW'($urandom));
         if ($urandom % 4 == 0) begin
            wait_n(1 + ($urandom % 5));
            do_start(SW'($urandom));
         end
         wait_n(1 + ($urandom % 60));
         cmp_in <= ~cmp_in;
         if ($urandom % 3 == 0) begin
            wait_n(1 + ($urandom % 2));
            cmp_in <= ~cmp_in;
         end
         wait_idle(200);
      end
      tick_mode = 0;
      wait_n(4);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule